// File: doc/BRIEF.md
# Two-Level Nested Interrupt Priority Controller

This block arbitrates five interrupt request sources for a small microcontroller core: two external inputs, two timer overflows and one serial port. Requests arrive as already-latched one-cycle pulses. Each pulse sets a pending flag that stays set until that source is granted. Software assigns each source to a low or high priority level. It also sets a per-source enable mask and a global enable bit. The controller tracks which levels are currently in service.

On each cycle the controller picks a winner from the enabled pending requests. A high-level request is chosen over any low-level one. Within a level, a fixed polling order breaks ties. The controller grants the winner only if no handler of the same or a higher level is running. A grant appears as a one-cycle strobe with a 3-bit source index and the level of the grant.

Nesting is limited to two levels, so a high-level request can preempt a low-level handler. A return-from-interrupt pulse closes the innermost active level. The core then resumes the preempted low-level handler.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Sources are indexed 0 to 4 in polling order: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. Among simultaneous eligible requests at one level, the lowest index is granted first.
- R2: After reset, the following are all clear: the priority bits (so every source is low level), the enable mask, the global enable, every pending flag, both in-service flags and the grant strobe.
- R3: An eligible high-level request is granted while only a low-level handler is in service. The grant reports level high, and after it both in-service flags are set.
- R4: A request at the same level as, or a lower level than, the handler in service is not granted. It stays pending until a return pulse frees its level.
- R5: While no high-level handler is in service, any eligible high-level request wins over every low-level request, whatever their polling order.
- R6: A pending request whose source enable bit is clear, or any request while the global enable is clear, is never granted and stays pending.
- R7: A grant is a one-cycle strobe `take_o`. It appears on the clock edge after the request became pending. It clears only the pending flag of the granted source.
- R8: A return pulse clears the high in-service flag if it is set, and otherwise the low one. No grant is issued on the edge where a return pulse is accepted.
- R9: A write to the priority register or to the enable mask takes effect from the next arbitration. A request that was held back is then granted.
- R10: A request pulse sets that source's pending flag. If the pulse coincides with the edge that grants the same source, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 5 | Latched request pulses, one bit per source index |
| prio_we_i | input | 1 | Write strobe for the priority register |
| prio_i | input | 5 | New priority bits, 1 = high level |
| mask_we_i | input | 1 | Write strobe for source enables and global enable |
| src_en_i | input | 5 | New per-source enable bits |
| glob_en_i | input | 1 | New global enable bit |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | One-cycle grant strobe |
| take_idx_o | output | 3 | Granted source index, valid with take_o |
| take_hi_o | output | 1 | Level of the grant, 1 = high, valid with take_o |
| pend_o | output | 5 | Current pending flags |
| svc_lo_o | output | 1 | Low level in service |
| svc_hi_o | output | 1 | High level in service |

## Verification
The bench targets the following corner cases:
- **Preemption.** A high-level request arrives while a low-level handler runs. A design without nesting would hold it back. A design that ignored the running level would also let same-level requests through, and the same-level and lower-level holds catch that.
- **Priority against polling order.** A high-level request with a late polling position competes against a low-level request at index 0. A controller that used the polling order alone would pick the wrong source.
- **Return pulses.** They are checked for popping only the innermost level and for suppressing a grant on their own edge. A wrong pop resumes the wrong level. A missing suppression grants one cycle too early.
- **Gating and pending-flag edges.** Disabled and globally masked requests must stay pending until enabled. A request pulse that coincides with its own grant must survive. A design that cleared flags too broadly would lose requests.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the nested interrupt controller.
// Assumes a fixed set of five sources; the index width follows from it.
package irq_nest_pkg;
    localparam int unsigned NSRC  = 5;
    localparam int unsigned IDX_W = $clog2(NSRC);

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;
endpackage

// File: rtl/irq_nest_pend.sv
`timescale 1ns/1ps
// Module: pending flag bank.
// Holds one pending flag per source. A set pulse wins over a clear in the same
// cycle, so a fresh request is never lost to the grant of its older instance.
// Assumes set pulses are already synchronised and latched upstream.
module irq_nest_pend #(
    parameter int unsigned N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] pend_q;

    // Update pending flags: clear the acknowledged source, then apply new requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_chk
            assert_set_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[g] |=> pend_q[g]);
        end
    endgenerate
endmodule

// File: rtl/irq_nest_arb.sv
`timescale 1ns/1ps
// Module: two-level arbiter (combinational).
// Splits eligible requests into high and low pools. The high pool wins when no
// high handler runs. The low pool is used only when no handler runs at all.
// Inside the chosen pool, the lowest index wins. Assumes cand_i is already
// gated by the enables.
module irq_nest_arb #(
    parameter int unsigned N_SRC = 5,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N_SRC-1:0] cand_i,
    input  logic [N_SRC-1:0] prio_i,
    input  logic             svc_lo_i,
    input  logic             svc_hi_i,
    input  logic             block_i,
    output logic             gnt_o,
    output logic [IDX_W-1:0] gnt_idx_o,
    output logic             gnt_hi_o,
    output logic [N_SRC-1:0] gnt_mask_o
);
    logic [N_SRC-1:0] hi_pool;
    logic [N_SRC-1:0] lo_pool;
    logic [N_SRC-1:0] pool;
    logic             use_hi;
    logic             use_lo;

    // Split candidates by level and decide which level may be served.
    always_comb begin
        hi_pool = cand_i & prio_i;
        lo_pool = cand_i & ~prio_i;
        use_hi  = (|hi_pool) && !svc_hi_i;
        use_lo  = !use_hi && (|lo_pool) && !svc_hi_i && !svc_lo_i;
        pool    = use_hi ? hi_pool : lo_pool;
    end

    // Fixed polling order inside the chosen level: lowest index wins.
    always_comb begin
        gnt_idx_o  = '0;
        gnt_mask_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pool[i]) begin
                gnt_idx_o  = i[IDX_W-1:0];
                gnt_mask_o = '0;
                gnt_mask_o[i] = 1'b1;
            end
        end
        gnt_o    = !block_i && (use_hi || use_lo);
        gnt_hi_o = use_hi;
        if (!gnt_o) gnt_mask_o = '0;
    end
endmodule

// File: rtl/irq_nest_svc.sv
`timescale 1ns/1ps
// Module: two-entry in-service stack.
// One flag per level. A grant sets the flag of its level. A return pulse clears
// the highest flag set, closing the innermost handler. Assumes the return
// pulse and a grant never arrive together; the arbiter blocks that case.
module irq_nest_svc (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic take_hi_i,
    input  logic ret_i,
    output logic lo_o,
    output logic hi_o
);
    logic lo_q;
    logic hi_q;

    // Push on grant, pop the innermost level on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= 1'b0;
            hi_q <= 1'b0;
        end else if (ret_i) begin
            if (hi_q) hi_q <= 1'b0;
            else      lo_q <= 1'b0;
        end else if (take_i) begin
            if (take_hi_i) hi_q <= 1'b1;
            else           lo_q <= 1'b1;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    assert_ret_pops_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && hi_q) |=> (!hi_q && (lo_q == $past(lo_q))));
    assert_ret_pops_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !hi_q) |=> (!lo_q && !hi_q));
endmodule

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
// Module: two-level nested interrupt priority controller (top).
// Holds the priority and enable registers. Gates pending requests, arbitrates
// them and registers a one-cycle grant strobe with index and level. A return
// pulse blocks arbitration in its own cycle. Assumes request inputs are
// latched pulses and that config writes come from a core-side register port.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int unsigned N_SRC = NSRC,
    parameter int unsigned IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_i,
    input  logic             prio_we_i,
    input  logic [N_SRC-1:0] prio_i,
    input  logic             mask_we_i,
    input  logic [N_SRC-1:0] src_en_i,
    input  logic             glob_en_i,
    input  logic             reti_i,
    output logic             take_o,
    output logic [IDX_W-1:0] take_idx_o,
    output logic             take_hi_o,
    output logic [N_SRC-1:0] pend_o,
    output logic             svc_lo_o,
    output logic             svc_hi_o
);
    logic [N_SRC-1:0] prio_q;
    logic [N_SRC-1:0] en_q;
    logic             gen_q;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] cand;
    logic             gnt;
    logic [IDX_W-1:0] gnt_idx;
    logic             gnt_hi;
    logic [N_SRC-1:0] gnt_mask;
    logic             svc_lo;
    logic             svc_hi;
    lvl_e             gnt_lvl;

    // Software-visible configuration: priority bits and enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            gen_q  <= 1'b0;
        end else begin
            if (prio_we_i) prio_q <= prio_i;
            if (mask_we_i) begin
                en_q  <= src_en_i;
                gen_q <= glob_en_i;
            end
        end
    end

    irq_nest_pend #(.N_SRC(N_SRC)) i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_i),
        .clr_i  (gnt_mask),
        .pend_o (pend)
    );

    // Gate pending requests with per-source and global enables.
    always_comb cand = pend & en_q & {N_SRC{gen_q}};

    irq_nest_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_arb (
        .cand_i     (cand),
        .prio_i     (prio_q),
        .svc_lo_i   (svc_lo),
        .svc_hi_i   (svc_hi),
        .block_i    (reti_i),
        .gnt_o      (gnt),
        .gnt_idx_o  (gnt_idx),
        .gnt_hi_o   (gnt_hi),
        .gnt_mask_o (gnt_mask)
    );

    irq_nest_svc i_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (gnt),
        .take_hi_i (gnt_hi),
        .ret_i     (reti_i),
        .lo_o      (svc_lo),
        .hi_o      (svc_hi)
    );

    // Map the arbiter level bit onto the level type.
    always_comb gnt_lvl = gnt_hi ? LVL_HI : LVL_LO;

    // Register the grant strobe, index and level for the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            take_idx_o <= '0;
            take_hi_o  <= 1'b0;
        end else begin
            take_o <= gnt;
            if (gnt) begin
                take_idx_o <= gnt_idx;
                take_hi_o  <= (gnt_lvl == LVL_HI);
            end
        end
    end

    assign pend_o   = pend;
    assign svc_lo_o = svc_lo;
    assign svc_hi_o = svc_hi;

    assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (32'(take_idx_o) < N_SRC));
    assert_take_marks_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (take_hi_o ? svc_hi : svc_lo));
    assert_no_peer_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && !gnt_hi) |-> (!svc_lo && !svc_hi));
    assert_high_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && (|(cand & prio_q)) && !svc_hi) |-> gnt_hi);
    assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_q |-> !gnt);
    assert_single_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_mask));
    assert_reti_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !take_o);
endmodule

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed
// scenarios with hard expected values per requirement.
module test_irq_nest_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] irq = '0;
    logic       pwe = 1'b0;
    logic [4:0] pval = '0;
    logic       mwe = 1'b0;
    logic [4:0] mval = '0;
    logic       gval = 1'b0;
    logic       reti = 1'b0;
    logic       take;
    logic [2:0] tidx;
    logic       thi;
    logic [4:0] pend;
    logic       slo;
    logic       shi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_nest_ctrl i_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .prio_we_i(pwe), .prio_i(pval),
        .mask_we_i(mwe), .src_en_i(mval), .glob_en_i(gval),
        .reti_i(reti),
        .take_o(take), .take_idx_o(tidx), .take_hi_o(thi),
        .pend_o(pend), .svc_lo_o(slo), .svc_hi_o(shi)
    );

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Reference model state
    bit [4:0] m_pend, m_prio, m_en;
    bit       m_gen, m_slo, m_shi, m_take, m_hi;
    int       m_idx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_prio = '0; m_en = '0; m_gen = 0;
            m_slo = 0; m_shi = 0; m_take = 0; m_hi = 0; m_idx = 0;
        end else begin
            int w;
            bit wh;
            w = -1;
            wh = 0;
            if (!reti && m_gen) begin
                if (!m_shi)
                    for (int i = 0; i < 5; i++)
                        if (w < 0 && m_pend[i] && m_en[i] && m_prio[i]) begin w = i; wh = 1; end
                if (w < 0 && !m_shi && !m_slo)
                    for (int i = 0; i < 5; i++)
                        if (w < 0 && m_pend[i] && m_en[i] && !m_prio[i]) w = i;
            end
            m_take = (w >= 0);
            if (m_take) begin
                m_idx = w; m_hi = wh; m_pend[w] = 0;
                if (wh) m_shi = 1; else m_slo = 1;
            end
            if (reti) begin
                if (m_shi) m_shi = 0; else m_slo = 0;
            end
            m_pend = m_pend | irq;
            if (pwe) m_prio = pval;
            if (mwe) begin m_en = mval; m_gen = gval; end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7", int'(take), int'(m_take), "grant strobe vs model");
            if (m_take) begin
                chk("R1", int'(tidx), m_idx, "grant index vs model");
                chk("R5", int'(thi), int'(m_hi), "grant level vs model");
            end
            chk("R8", int'({shi, slo}), int'({m_shi, m_slo}), "in-service flags vs model");
            chk("R10", int'(pend), int'(m_pend), "pending flags vs model");
        end
    end

    task automatic cyc(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic fire(logic [4:0] v);
        irq = v; cyc(); irq = '0;
    endtask

    task automatic ret();
        reti = 1'b1; cyc(); reti = 1'b0;
    endtask

    task automatic set_prio(logic [4:0] v);
        pwe = 1'b1; pval = v; cyc(); pwe = 1'b0;
    endtask

    task automatic set_mask(logic [4:0] v, logic g);
        mwe = 1'b1; mval = v; gval = g; cyc(); mwe = 1'b0;
    endtask

    task automatic exp_take(string tag, int idx, int hi);
        chk(tag, int'(take), 1, "take strobe");
        chk(tag, int'(tidx), idx, "take index");
        chk(tag, int'(thi), hi, "take level");
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R2: reset state at the ports
        chk("R2", int'(take), 0, "take after reset");
        chk("R2", int'(pend), 0, "pending after reset");
        chk("R2", int'({shi, slo}), 0, "in-service after reset");

        // R2: priority bits reset to low; source 3 then source 0 are peers
        set_mask(5'b11111, 1'b1);
        fire(5'b01000);
        cyc();
        exp_take("R2", 3, 0);
        fire(5'b00001);
        cyc(2);
        chk("R2", int'(take), 0, "index 0 not preempting at reset priority");
        chk("R4", int'(pend[0]), 1, "held request stays pending");
        ret();
        chk("R8", int'(take), 0, "no grant on return edge");
        cyc();
        exp_take("R2", 0, 0);
        ret();

        // R1 / R7: simultaneous low requests, polling order and single clear
        fire(5'b01010);
        cyc();
        exp_take("R1", 1, 0);
        chk("R7", int'(pend), 5'b01000, "only winner cleared");
        cyc();
        chk("R7", int'(take), 0, "strobe lasts one cycle");
        ret();
        cyc();
        exp_take("R4", 3, 0);
        ret();

        // R3 / R8: high-level preemption of a low handler, then nested returns
        set_prio(5'b01000);
        fire(5'b10000);
        cyc();
        exp_take("R3", 4, 0);
        fire(5'b01000);
        cyc();
        exp_take("R3", 3, 1);
        chk("R3", int'({shi, slo}), 3, "both levels in service");
        ret();
        chk("R8", int'({shi, slo}), 1, "return pops high only");
        ret();
        chk("R8", int'({shi, slo}), 0, "second return pops low");

        // R5: high beats lower-index low request
        fire(5'b01001);
        cyc();
        exp_take("R5", 3, 1);
        ret();
        cyc();
        exp_take("R5", 0, 0);
        ret();

        // R4: same-level high does not preempt high
        set_prio(5'b01001);
        fire(5'b01000);
        cyc();
        exp_take("R4", 3, 1);
        fire(5'b00001);
        cyc(2);
        chk("R4", int'(take), 0, "high peer held");
        ret();
        cyc();
        exp_take("R4", 0, 1);
        ret();

        // R6 / R9: disabled source held, then enabled
        set_mask(5'b11011, 1'b1);
        fire(5'b00100);
        cyc(3);
        chk("R6", int'(take), 0, "disabled source not granted");
        chk("R6", int'(pend[2]), 1, "disabled source stays pending");
        set_mask(5'b11111, 1'b1);
        cyc();
        exp_take("R9", 2, 0);
        ret();

        // R6 / R9: global enable off
        set_mask(5'b11111, 1'b0);
        fire(5'b00010);
        cyc(3);
        chk("R6", int'(take), 0, "global disable blocks grant");
        chk("R6", int'(pend[1]), 1, "request kept under global disable");
        set_mask(5'b11111, 1'b1);
        cyc();
        exp_take("R9", 1, 0);
        ret();

        // R9: priority change at run time lifts a held low request
        set_prio(5'b00000);
        fire(5'b00001);
        cyc();
        exp_take("R9", 0, 0);
        fire(5'b00010);
        cyc(2);
        chk("R9", int'(take), 0, "held while low level busy");
        set_prio(5'b00010);
        cyc();
        exp_take("R9", 1, 1);
        ret();
        ret();

        // R10: request pulse on the grant edge of the same source survives
        irq = 5'b10000;
        cyc();
        cyc();
        irq = '0;
        exp_take("R10", 4, 0);
        chk("R10", int'(pend[4]), 1, "pending kept after coincident set");
        ret();
        cyc();
        exp_take("R10", 4, 0);
        ret();
        cyc(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule